// File: doc/BRIEF.md
# Alternating Two-Buffer Ownership Controller

This block manages a pair of memory buffers, A and B, that carry one direction of traffic between a host and a byte-oriented channel. Each buffer has one ownership flag. While the flag is clear the host owns the buffer. It may program the buffer's base address and length, and fill or empty it. Once the host hands the buffer over, the controller owns it and moves bytes through it until the programmed length is used up. The controller then hands the buffer back and raises a one-cycle done interrupt.

The controller works on exactly one buffer at a time and takes them strictly in the order A, B, A, B. If the buffer next in line is still owned by the host, the controller waits. It never jumps ahead to the other buffer. The block behaves the same in either direction. For sending, the host fills a buffer, hands it over and sets the run flag (the transmit command). For receiving, the host hands over empty buffers and collects each one as its done interrupt arrives. The channel side asks for one byte move at a time. The block grants the move and supplies the memory address for that byte.

Top module: `dbuf_dma_ctrl`

## Requirements
- R1: After reset, both buffers are host-owned, the next buffer is A, the run flag is clear and `done_irq` is low. Reading register 4 returns 0.
- R2: A write to register 4 with bit 0 set hands buffer A to the controller, and bit 1 does the same for B. The hand-over takes effect only if that buffer's length is nonzero. Status bits in register 4 are: bit 0 controller owns A, bit 1 controller owns B, bit 2 next buffer (0 = A, 1 = B), bit 3 run flag.
- R3: Registers 0 (base A), 1 (length A), 2 (base B) and 3 (length B) are writable and readable. A write to a buffer's base or length while the controller owns that buffer leaves it unchanged.
- R4: `xfer_ack` is high only when `xfer_stb` is high, the run flag is set and the controller owns the next buffer. If the next buffer is host-owned, no byte is accepted, even when the other buffer is controller-owned.
- R5: `xfer_addr` equals the active buffer's base plus the number of bytes already moved in it. That count starts at 0 each time a buffer becomes active.
- R6: The beat that moves byte number length−1 returns the buffer to the host and switches the next buffer to the other one.
- R7: In the cycle after that final beat, `done_irq` is high for exactly one cycle, and `done_buf` names the finished buffer (0 = A, 1 = B).
- R8: Buffers are serviced strictly in the order A, B, A, B.
- R9: Register 4 bit 2 sets the run flag and bit 3 clears it. Clearing the flag stops acceptance but keeps the position inside the active buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_waddr | input | 3 | Host write register index |
| host_wdata | input | REG_W | Host write data |
| host_raddr | input | 3 | Host read register index |
| host_rdata | output | REG_W | Host read data, combinational |
| xfer_stb | input | 1 | Channel requests one byte move |
| xfer_ack | output | 1 | Byte move granted this cycle |
| xfer_addr | output | ADDR_W | Memory address for the granted byte |
| xfer_buf | output | 1 | Buffer currently next in line (0 = A) |
| done_irq | output | 1 | One-cycle pulse when a buffer completes |
| done_buf | output | 1 | Buffer that completed |

## Verification
The hardest case to reach from the ports is a stall on sequence: the next buffer is host-owned while the other buffer is already back in the controller's hands. It tempts a design to skip ahead. The bench drains A, hands A straight back before B has ever been given, and then requests bytes. Acceptance must stay low, and the first byte after B is handed over must come from B's base. Pausing the run flag in the middle of a buffer is reached the same way, and the bench confirms the next address continues where it left off.

// File: rtl/dbuf_pkg.sv
// Package: shared register indices and buffer identifiers for the
// two-buffer ownership controller. Assumes a 3-bit host register index.
package dbuf_pkg;
    localparam logic [2:0] REG_BASE_A = 3'd0;
    localparam logic [2:0] REG_LEN_A  = 3'd1;
    localparam logic [2:0] REG_BASE_B = 3'd2;
    localparam logic [2:0] REG_LEN_B  = 3'd3;
    localparam logic [2:0] REG_CTRL   = 3'd4;

    localparam int CTRL_GIVE_A  = 0;
    localparam int CTRL_GIVE_B  = 1;
    localparam int CTRL_RUN_SET = 2;
    localparam int CTRL_RUN_CLR = 3;

    typedef enum logic {
        BUF_A = 1'b0,
        BUF_B = 1'b1
    } buf_id_t;
endpackage

// File: rtl/dbuf_slot.sv
// Module: one buffer descriptor (base, length, ownership flag).
// The host may change base and length only while it owns the slot.
// A hand-over is refused when the length is zero or the slot is already
// owned. Assumes give and release never target the slot as a pair that
// conflicts: release only occurs while owned, give only while not owned.
module dbuf_slot #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_base,
    input  logic              wr_len,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [LEN_W-1:0]  len_in,
    input  logic              give,
    input  logic              release_i,
    output logic [ADDR_W-1:0] base,
    output logic [LEN_W-1:0]  len,
    output logic              own
);
    // Descriptor fields: host writes accepted only while host-owned.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            len  <= '0;
        end else if (!own) begin
            if (wr_base) base <= base_in;
            if (wr_len)  len  <= len_in;
        end
    end

    // Ownership flag: set by a valid hand-over, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                                own <= 1'b0;
        else if (own && release_i)                 own <= 1'b0;
        else if (!own && give && (len != '0))      own <= 1'b1;
    end
endmodule

// File: rtl/dbuf_seq.sv
// Module: sequencer. Tracks the next buffer, the byte count inside it and
// the run flag. It grants one byte per cycle when the next buffer is
// controller-owned, then releases the buffer and pulses the done interrupt
// after the last byte. Assumes an owned buffer has a nonzero length.
module dbuf_seq #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             run_set,
    input  logic             run_clr,
    input  logic [1:0]       own,
    input  logic [LEN_W-1:0] cur_len,
    output logic             ack,
    output logic             sel,
    output logic             run,
    output logic [LEN_W-1:0] cnt,
    output logic [1:0]       release_o,
    output logic             irq,
    output logic             irq_buf
);
    logic last_beat;

    // Grant and final-beat detection for the buffer next in line.
    always_comb begin
        ack       = stb && run && own[sel];
        last_beat = ack && ({1'b0, cnt} + 1'b1 == {1'b0, cur_len});
        release_o = '0;
        release_o[sel] = last_beat;
    end

    // Run flag: set and clear commands, clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       run <= 1'b0;
        else if (run_clr) run <= 1'b0;
        else if (run_set) run <= 1'b1;
    end

    // Position: byte count and next-buffer pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sel <= dbuf_pkg::BUF_A;
        end else if (last_beat) begin
            cnt <= '0;
            sel <= ~sel;
        end else if (ack) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Done interrupt: one-cycle pulse naming the finished buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            irq_buf <= 1'b0;
        end else begin
            irq <= last_beat;
            if (last_beat) irq_buf <= sel;
        end
    end
endmodule

// File: rtl/dbuf_dma_ctrl.sv
// Module: top of the two-buffer ownership controller. Decodes host
// register writes, holds two descriptor slots, and drives the byte-move
// port through the sequencer. Assumes REG_W >= ADDR_W and REG_W >= LEN_W.
module dbuf_dma_ctrl #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [2:0]        host_waddr,
    input  logic [REG_W-1:0]  host_wdata,
    input  logic [2:0]        host_raddr,
    output logic [REG_W-1:0]  host_rdata,
    input  logic              xfer_stb,
    output logic              xfer_ack,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              xfer_buf,
    output logic              done_irq,
    output logic              done_buf
);
    import dbuf_pkg::*;

    localparam int NBUF = 2;

    logic [ADDR_W-1:0] slot_base [NBUF];
    logic [LEN_W-1:0]  slot_len  [NBUF];
    logic [NBUF-1:0]   own_vec;
    logic [NBUF-1:0]   give_vec;
    logic [NBUF-1:0]   rel_vec;
    logic [NBUF-1:0]   wr_base_vec;
    logic [NBUF-1:0]   wr_len_vec;
    logic              ctrl_wr;
    logic              cur_sel;
    logic              run_flag;
    logic [LEN_W-1:0]  cur_cnt;

    // Host write decode into per-slot strobes and commands.
    always_comb begin
        ctrl_wr     = host_wr && (host_waddr == REG_CTRL);
        wr_base_vec = {host_wr && (host_waddr == REG_BASE_B),
                       host_wr && (host_waddr == REG_BASE_A)};
        wr_len_vec  = {host_wr && (host_waddr == REG_LEN_B),
                       host_wr && (host_waddr == REG_LEN_A)};
        give_vec    = {ctrl_wr && host_wdata[CTRL_GIVE_B],
                       ctrl_wr && host_wdata[CTRL_GIVE_A]};
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_slot
        dbuf_slot #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_base  (wr_base_vec[g]),
            .wr_len   (wr_len_vec[g]),
            .base_in  (host_wdata[ADDR_W-1:0]),
            .len_in   (host_wdata[LEN_W-1:0]),
            .give     (give_vec[g]),
            .release_i(rel_vec[g]),
            .base     (slot_base[g]),
            .len      (slot_len[g]),
            .own      (own_vec[g])
        );
    end

    dbuf_seq #(.LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (xfer_stb),
        .run_set  (ctrl_wr && host_wdata[CTRL_RUN_SET]),
        .run_clr  (ctrl_wr && host_wdata[CTRL_RUN_CLR]),
        .own      (own_vec),
        .cur_len  (slot_len[cur_sel]),
        .ack      (xfer_ack),
        .sel      (cur_sel),
        .run      (run_flag),
        .cnt      (cur_cnt),
        .release_o(rel_vec),
        .irq      (done_irq),
        .irq_buf  (done_buf)
    );

    // Byte address and next-buffer indication toward the channel side.
    always_comb begin
        xfer_addr = slot_base[cur_sel] + ADDR_W'(cur_cnt);
        xfer_buf  = cur_sel;
    end

    // Host read mux.
    always_comb begin
        host_rdata = '0;
        case (host_raddr)
            REG_BASE_A: host_rdata = REG_W'(slot_base[0]);
            REG_LEN_A:  host_rdata = REG_W'(slot_len[0]);
            REG_BASE_B: host_rdata = REG_W'(slot_base[1]);
            REG_LEN_B:  host_rdata = REG_W'(slot_len[1]);
            REG_CTRL:   host_rdata = REG_W'({run_flag, cur_sel, own_vec});
            default:    host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dbuf_dma_chk.sv
// Module: property checker for the ownership controller, bound to the top.
// Observes ports plus the ownership flags, next pointer and base of A.
module dbuf_dma_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_stb,
    input logic              xfer_ack,
    input logic              done_irq,
    input logic              done_buf,
    input logic [1:0]        own,
    input logic              sel,
    input logic [ADDR_W-1:0] base_a
);
    assert_base_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        own[0] |=> $stable(base_a));

    assert_no_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !own[sel] |-> !xfer_ack);

    assert_ack_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |-> xfer_stb);

    assert_owner_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !own[done_buf]);

    assert_irq_after_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> $past(xfer_ack));

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    assert_alternate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (sel != done_buf));
endmodule

bind dbuf_dma_ctrl dbuf_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .xfer_stb(xfer_stb),
    .xfer_ack(xfer_ack),
    .done_irq(done_irq),
    .done_buf(done_buf),
    .own     (own_vec),
    .sel     (cur_sel),
    .base_a  (slot_base[0])
);

// File: tb/dbuf_dma_ctrl_tb.sv
module dbuf_dma_ctrl_tb;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 12;
    localparam int REG_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_wr = 1'b0;
    logic [2:0]        host_waddr = '0;
    logic [REG_W-1:0]  host_wdata = '0;
    logic [2:0]        host_raddr = '0;
    logic [REG_W-1:0]  host_rdata;
    logic              xfer_stb = 1'b0;
    logic              xfer_ack;
    logic [ADDR_W-1:0] xfer_addr;
    logic              xfer_buf;
    logic              done_irq;
    logic              done_buf;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    dbuf_dma_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .REG_W(REG_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_waddr(host_waddr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata),
        .xfer_stb(xfer_stb), .xfer_ack(xfer_ack), .xfer_addr(xfer_addr),
        .xfer_buf(xfer_buf), .done_irq(done_irq), .done_buf(done_buf)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_raddr = a;
        #0.5 d = host_rdata;
    endtask

    // One byte request expected to be granted at exp_addr.
    task automatic beat(input string req, input logic [15:0] exp_addr);
        @(negedge clk);
        xfer_stb = 1'b1;
        #0.5;
        check(req, {31'd0, xfer_ack}, 32'd1);
        check(req, {16'd0, xfer_addr}, {16'd0, exp_addr});
        @(posedge clk);
        #0.5 xfer_stb = 1'b0;
    endtask

    // One byte request expected to be refused.
    task automatic refused(input string req);
        @(negedge clk);
        xfer_stb = 1'b1;
        #0.5 check(req, {31'd0, xfer_ack}, 32'd0);
        @(posedge clk);
        #0.5 xfer_stb = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(3'd4, d);
        check("R1 status", d, 32'h0);
        check("R1 irq", {31'd0, done_irq}, 32'd0);
    endtask

    task automatic t_give_zero_len;
        logic [31:0] d;
        wr(3'd4, 32'h1);
        rd(3'd4, d);
        check("R2 zero length refused", d, 32'h0);
        wr(3'd0, 32'h0100);
        wr(3'd1, 32'd3);
        wr(3'd4, 32'h1);
        rd(3'd4, d);
        check("R2 give A", d, 32'h1);
    endtask

    task automatic t_locked;
        logic [31:0] d;
        wr(3'd0, 32'h0999);
        wr(3'd1, 32'd7);
        rd(3'd0, d);
        check("R3 base A locked", d, 32'h0100);
        rd(3'd1, d);
        check("R3 len A locked", d, 32'd3);
    endtask

    task automatic t_drain_a;
        logic [31:0] d;
        refused("R9 run clear blocks");
        wr(3'd4, 32'h4);
        beat("R5 A byte0", 16'h0100);
        beat("R5 A byte1", 16'h0101);
        beat("R6 A byte2", 16'h0102);
        @(negedge clk);
        check("R7 irq pulse", {31'd0, done_irq}, 32'd1);
        check("R7 done_buf A", {31'd0, done_buf}, 32'd0);
        host_raddr = 3'd4;
        #0.5 check("R6 A returned, next B", host_rdata, 32'hC);
        @(negedge clk);
        check("R7 irq one cycle", {31'd0, done_irq}, 32'd0);
        rd(3'd0, d);
        check("R3 base A writable when host-owned", d, 32'h0100);
    endtask

    task automatic t_stall_then_b;
        wr(3'd4, 32'h1);
        refused("R4 stall on host-owned B with A owned");
        check("R8 next is B", {31'd0, xfer_buf}, 32'd1);
        wr(3'd2, 32'h0200);
        wr(3'd3, 32'd2);
        wr(3'd4, 32'h2);
        beat("R8 B byte0", 16'h0200);
        beat("R8 B byte1", 16'h0201);
        @(negedge clk);
        check("R7 irq B", {31'd0, done_irq}, 32'd1);
        check("R7 done_buf B", {31'd0, done_buf}, 32'd1);
    endtask

    task automatic t_pause;
        logic [31:0] d;
        beat("R5 A restarts at base", 16'h0100);
        wr(3'd4, 32'h8);
        refused("R9 paused");
        rd(3'd4, d);
        check("R9 status run clear, A owned", d, 32'h1);
        wr(3'd4, 32'h4);
        beat("R9 resumes in place", 16'h0101);
        beat("R9 final A byte", 16'h0102);
        @(negedge clk);
        check("R8 A completes again", {31'd0, done_irq}, 32'd1);
        refused("R4 B host-owned after cycle");
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_give_zero_len();
        t_locked();
        t_drain_a();
        t_stall_then_b();
        t_pause();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule